// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one programmable output cell of a sum-of-products logic device. It takes the OR of a product-term array as its data input, plus three per-cell control terms: a clock/gate term, a clear term and a set term. One storage bit can act as a D flip-flop, a toggle flip-flop or a level-sensitive latch, or it can be bypassed so that the cell is plain combinational logic. The cell drives a pad value, a pad enable and a feedback value for the routing fabric. The feedback is always valid, so the cell also works as buried logic or a buried register.

The whole cell runs on one system clock `clk`. The global clock and the per-cell clock term are data-rate signals sampled by `clk`. An "active edge" is a 0-to-1 (or, when inverted, 1-to-0) change of the selected source between two consecutive `clk` samples. Static configuration bits choose the mode, the output polarity, the clock/gate source and its polarity. They are captured only while reset is in force. A test preload path and an observe override give direct access to the storage bit.

Top module: `omc_cell`

## Requirements
- R1: After reset the storage bit is 0, so a storage-mode cell shows 0 on `pad_o` when `cfg_out_inv_i`=0 and 1 when `cfg_out_inv_i`=1.
- R2: With `cfg_mode_i`=2'b00 (combinational) and observe off, `pad_o` equals `sop_i` XOR `cfg_out_inv_i` in the same cycle, with no clock involved.
- R3: With `cfg_mode_i`=2'b01 (D register), the storage bit takes `sop_i` on an active edge only and holds at every other cycle. The change is visible one `clk` cycle after the edge is sampled.
- R4: With `cfg_mode_i`=2'b10 (toggle register), an active edge with `sop_i`=1 inverts the storage bit, and one with `sop_i`=0 leaves it unchanged.
- R5: With `cfg_mode_i`=2'b11 (latch), the storage bit follows `sop_i` in every cycle while the selected source XOR `cfg_gate_inv_i` is 0 (transparent-low by default), and holds while it is 1.
- R6: `cfg_gate_pt_i`=0 selects `gclk_i` and 1 selects `pt_clk_i`. With `cfg_gate_inv_i`=0 the active edge is rising, and with 1 it is falling. The source that is not selected has no effect.
- R7: `pt_rst_i` forces the storage bit to 0 and `pt_set_i` forces it to 1, without needing any clock edge. When both are high, the result is 0.
- R8: `fb_o` always equals `pad_o` whatever `pt_oe_i` is. `pad_oe_o` follows `pt_oe_i` when observe is off.
- R9: `preload_en_i`=1 loads `preload_val_i` into the storage bit in any mode. A simultaneous `pt_rst_i` or `pt_set_i` overrides the preload.
- R10: With `observe_i`=1, `pad_oe_o` is 1 and the pads show the storage bit XOR `cfg_out_inv_i`. A combinational-mode cell then behaves as a D register whose data is 0.
- R11: The configuration inputs are sampled only while reset is in force. Changes after reset release have no effect.
- R12: Output polarity is applied after the storage bit, so a toggle register inverts the stored value and not the pad value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the cell |
| cfg_mode_i | input | 2 | 00 combinational, 01 D register, 10 toggle register, 11 latch |
| cfg_out_inv_i | input | 1 | 1 inverts pad and feedback after the storage bit |
| cfg_gate_pt_i | input | 1 | Clock/gate source: 0 global clock, 1 per-cell clock term |
| cfg_gate_inv_i | input | 1 | 1 inverts the selected clock/gate source |
| gclk_i | input | 1 | Global clock/gate signal, sampled by clk |
| pt_clk_i | input | 1 | Per-cell clock/gate product term |
| sop_i | input | 1 | Sum-of-products data term |
| pt_rst_i | input | 1 | Per-cell clear term, higher priority than set |
| pt_set_i | input | 1 | Per-cell set term |
| pt_oe_i | input | 1 | Per-cell output-enable term |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 1 | Value loaded by the preload |
| observe_i | input | 1 | Test observe override |
| pad_o | output | 1 | Value to the I/O cell |
| pad_oe_o | output | 1 | Enable to the I/O cell |
| fb_o | output | 1 | Feedback to the routing fabric |

## Verification
A wrong storage bit shows on `pad_o` and `fb_o` in the cycle after the faulty update, because nothing lies between the bit and the pads except the polarity gate. A fault in the edge detector or in the source choice shows up as a capture that is missing, late or extra, one cycle after the edge that was sampled. A configuration that is captured wrongly or drifts shows at the first stimulus that tells two modes apart. This is why each scenario starts from a fresh reset, and why the frozen-configuration test changes the mode inputs after reset release and then applies data that only a combinational cell would pass through.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_DREG  = 2'b01,
    MODE_TREG  = 2'b10,
    MODE_LATCH = 2'b11
  } omc_mode_e;

  typedef struct packed {
    omc_mode_e mode;
    logic      out_inv;
    logic      gate_pt;
    logic      gate_inv;
  } omc_cfg_t;

endpackage

// File: rtl/omc_cfg_hold.sv
module omc_cfg_hold
  import omc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  omc_cfg_t cfg_i,
  output omc_cfg_t cfg_o
);

  omc_cfg_t cfg_q;
  logic     cap_en;

  // Snapshot only while reset is held (R11)
  assign cap_en = !rst_n;

  always_ff @(posedge clk) begin
    if (cap_en) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/omc_gate_sel.sv
module omc_gate_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic gclk_i,
  input  logic pt_clk_i,
  input  logic use_pt_i,
  input  logic inv_i,
  output logic edge_o,
  output logic open_o
);

  logic src;
  logic src_prev;
  logic lvl;
  logic lvl_prev;

  assign src = use_pt_i ? pt_clk_i : gclk_i;

  // History flop runs through reset so no false edge appears at release
  always_ff @(posedge clk) begin
    src_prev <= src;
  end

  assign lvl      = src ^ inv_i;
  assign lvl_prev = src_prev ^ inv_i;
  assign edge_o   = lvl & ~lvl_prev;
  assign open_o   = ~lvl;

  p_edge_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/omc_store.sv
module omc_store
  import omc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  omc_mode_e mode_i,
  input  logic      d_i,
  input  logic      edge_i,
  input  logic      open_i,
  input  logic      clr_i,
  input  logic      set_i,
  input  logic      pl_en_i,
  input  logic      pl_val_i,
  output logic      q_o
);

  logic q_q;
  logic q_nxt;

  always_comb begin
    q_nxt = q_q;
    if (clr_i) begin
      q_nxt = 1'b0;
    end else if (set_i) begin
      q_nxt = 1'b1;
    end else if (pl_en_i) begin
      q_nxt = pl_val_i;
    end else begin
      case (mode_i)
        MODE_DREG:  if (edge_i) q_nxt = d_i;
        MODE_TREG:  if (edge_i && d_i) q_nxt = ~q_q;
        MODE_LATCH: if (open_i) q_nxt = d_i;
        default:    q_nxt = q_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_nxt;
  end

  assign q_o = q_q;

  logic quiet;
  assign quiet = !clr_i && !set_i && !pl_en_i;

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  p_set_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> q_o);
  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_en_i && !clr_i && !set_i |=> q_o == $past(pl_val_i));
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && mode_i == MODE_TREG && edge_i && d_i |=> q_o != $past(q_o));
  p_hold_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (mode_i == MODE_DREG || mode_i == MODE_TREG) && !edge_i |=> $stable(q_o));
  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && mode_i == MODE_LATCH && open_i |=> q_o == $past(d_i));

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_out_inv_i,
  input  logic       cfg_gate_pt_i,
  input  logic       cfg_gate_inv_i,
  input  logic       gclk_i,
  input  logic       pt_clk_i,
  input  logic       sop_i,
  input  logic       pt_rst_i,
  input  logic       pt_set_i,
  input  logic       pt_oe_i,
  input  logic       preload_en_i,
  input  logic       preload_val_i,
  input  logic       observe_i,
  output logic       pad_o,
  output logic       pad_oe_o,
  output logic       fb_o
);

  localparam int LAST = RST_STAGES - 1;

  // Asynchronous assert, synchronous release
  logic [LAST:0] rsync_q;
  logic          rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[LAST-1:0], 1'b1};
  end

  assign rst_q_n = rsync_q[LAST];

  omc_cfg_t  cfg_in;
  omc_cfg_t  cfg;
  logic      g_edge;
  logic      g_open;
  logic      force_d;
  omc_mode_e mode_eff;
  logic      d_eff;
  logic      q;
  logic      core;

  assign cfg_in.mode     = omc_mode_e'(cfg_mode_i);
  assign cfg_in.out_inv  = cfg_out_inv_i;
  assign cfg_in.gate_pt  = cfg_gate_pt_i;
  assign cfg_in.gate_inv = cfg_gate_inv_i;

  omc_cfg_hold u_cfg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .cfg_i (cfg_in),
    .cfg_o (cfg)
  );

  omc_gate_sel u_gate (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .gclk_i   (gclk_i),
    .pt_clk_i (pt_clk_i),
    .use_pt_i (cfg.gate_pt),
    .inv_i    (cfg.gate_inv),
    .edge_o   (g_edge),
    .open_o   (g_open)
  );

  // Observe turns a bypass cell into a D register fed with 0
  assign force_d  = observe_i && (cfg.mode == MODE_COMB);
  assign mode_eff = force_d ? MODE_DREG : cfg.mode;
  assign d_eff    = force_d ? 1'b0 : sop_i;

  omc_store u_store (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .mode_i   (mode_eff),
    .d_i      (d_eff),
    .edge_i   (g_edge),
    .open_i   (g_open),
    .clr_i    (pt_rst_i),
    .set_i    (pt_set_i),
    .pl_en_i  (preload_en_i),
    .pl_val_i (preload_val_i),
    .q_o      (q)
  );

  // Polarity sits after storage on both paths
  assign core     = (cfg.mode == MODE_COMB && !observe_i) ? sop_i : q;
  assign pad_o    = core ^ cfg.out_inv;
  assign fb_o     = core ^ cfg.out_inv;
  assign pad_oe_o = pt_oe_i | observe_i;

endmodule

// File: tb/test_omc_cell.sv
module test_omc_cell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic       cfg_out_inv, cfg_gate_pt, cfg_gate_inv;
  logic       gclk, pt_clk, sop, pt_rst, pt_set, pt_oe;
  logic       pl_en, pl_val, observe;
  logic       pad, pad_oe, fb;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  omc_cell i_omc_cell (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode_i     (cfg_mode),
    .cfg_out_inv_i  (cfg_out_inv),
    .cfg_gate_pt_i  (cfg_gate_pt),
    .cfg_gate_inv_i (cfg_gate_inv),
    .gclk_i         (gclk),
    .pt_clk_i       (pt_clk),
    .sop_i          (sop),
    .pt_rst_i       (pt_rst),
    .pt_set_i       (pt_set),
    .pt_oe_i        (pt_oe),
    .preload_en_i   (pl_en),
    .preload_val_i  (pl_val),
    .observe_i      (observe),
    .pad_o          (pad),
    .pad_oe_o       (pad_oe),
    .fb_o           (fb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic oinv,
                          input logic gpt, input logic ginv);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_mode = mode; cfg_out_inv = oinv; cfg_gate_pt = gpt; cfg_gate_inv = ginv;
    gclk = 1'b0; pt_clk = 1'b0; sop = 1'b0; pt_rst = 1'b0; pt_set = 1'b0;
    pt_oe = 1'b0; pl_en = 1'b0; pl_val = 1'b0; observe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic on_pt);
    if (on_pt) pt_clk = 1'b1; else gclk = 1'b1;
    tick();
    if (on_pt) pt_clk = 1'b0; else gclk = 1'b0;
    tick();
  endtask

  task automatic t_reset_state();
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    check("R1 reset low", pad, 1'b0);
    check("R1 reset fb", fb, 1'b0);
    do_reset(2'b01, 1'b1, 1'b0, 1'b0);
    check("R1 reset inverted", pad, 1'b1);
  endtask

  task automatic t_comb();
    do_reset(2'b00, 1'b0, 1'b0, 1'b0);
    sop = 1'b1; settle();
    check("R2 comb high", pad, 1'b1);
    check("R8 fb with oe off", fb, 1'b1);
    check("R8 pad_oe follows term", pad_oe, 1'b0);
    pt_oe = 1'b1; settle();
    check("R8 pad_oe on", pad_oe, 1'b1);
    sop = 1'b0; settle();
    check("R2 comb low", pad, 1'b0);
    do_reset(2'b00, 1'b1, 1'b0, 1'b0);
    sop = 1'b0; settle();
    check("R2 comb inverted", pad, 1'b1);
    check("R8 fb inverted", fb, 1'b1);
  endtask

  task automatic t_dreg();
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    sop = 1'b1; tick();
    check("R3 no edge holds", pad, 1'b0);
    gclk = 1'b1; tick();
    check("R3 rising captures", pad, 1'b1);
    sop = 1'b0; tick();
    check("R3 level high holds", pad, 1'b1);
    gclk = 1'b0; tick();
    check("R6 falling ignored", pad, 1'b1);
    // falling edge selected
    do_reset(2'b01, 1'b0, 1'b0, 1'b1);
    sop = 1'b1; gclk = 1'b1; tick();
    check("R6 rising ignored when inverted", pad, 1'b0);
    gclk = 1'b0; tick();
    check("R6 falling captures", pad, 1'b1);
    // product-term source
    do_reset(2'b01, 1'b0, 1'b1, 1'b0);
    sop = 1'b1; pulse(1'b0);
    check("R6 global ignored when term selected", pad, 1'b0);
    pulse(1'b1);
    check("R6 term clock captures", pad, 1'b1);
  endtask

  task automatic t_treg();
    do_reset(2'b10, 1'b1, 1'b0, 1'b0);
    check("R12 reset inverted", pad, 1'b1);
    sop = 1'b1; pulse(1'b0);
    check("R4 first toggle", pad, 1'b0);
    check("R12 fb after toggle", fb, 1'b0);
    pulse(1'b0);
    check("R4 second toggle", pad, 1'b1);
    sop = 1'b0; pulse(1'b0);
    check("R4 T=0 holds", pad, 1'b1);
  endtask

  task automatic t_latch();
    do_reset(2'b11, 1'b0, 1'b0, 1'b0);
    sop = 1'b1; tick();
    check("R5 transparent follows 1", pad, 1'b1);
    sop = 1'b0; tick();
    check("R5 transparent follows 0", pad, 1'b0);
    gclk = 1'b1; sop = 1'b1; tick();
    check("R5 closed holds", pad, 1'b0);
    tick();
    check("R5 closed still holds", pad, 1'b0);
    do_reset(2'b11, 1'b0, 1'b0, 1'b1);
    sop = 1'b1; tick();
    check("R5 inverted gate closed", pad, 1'b0);
    gclk = 1'b1; tick();
    check("R5 inverted gate open", pad, 1'b1);
  endtask

  task automatic t_async();
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    pt_set = 1'b1; tick();
    check("R7 set without edge", pad, 1'b1);
    pt_set = 1'b0; tick();
    check("R7 holds after set", pad, 1'b1);
    pt_rst = 1'b1; tick();
    check("R7 clear without edge", pad, 1'b0);
    pt_rst = 1'b0; pt_set = 1'b1; tick();
    pt_rst = 1'b1; tick();
    check("R7 both high gives 0", pad, 1'b0);
    pt_rst = 1'b0; pt_set = 1'b0;
  endtask

  task automatic t_preload();
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    pl_en = 1'b1; pl_val = 1'b1; tick();
    check("R9 preload 1", pad, 1'b1);
    pl_val = 1'b0; tick();
    check("R9 preload 0", pad, 1'b0);
    pl_val = 1'b1; pt_rst = 1'b1; tick();
    check("R9 clear beats preload", pad, 1'b0);
    pt_rst = 1'b0; pl_val = 1'b0; pt_set = 1'b1; tick();
    check("R9 set beats preload", pad, 1'b1);
    pt_set = 1'b0; pl_en = 1'b0;
  endtask

  task automatic t_observe();
    do_reset(2'b00, 1'b0, 1'b0, 1'b0);
    sop = 1'b1; settle();
    check("R10 normal comb", pad, 1'b1);
    observe = 1'b1; settle();
    check("R10 observe shows storage", pad, 1'b0);
    check("R10 observe enables pad", pad_oe, 1'b1);
    pt_set = 1'b1; tick();
    pt_set = 1'b0; tick();
    check("R10 observe after set", pad, 1'b1);
    pulse(1'b0);
    check("R10 forced data zero", pad, 1'b0);
    observe = 1'b0; settle();
    check("R10 release observe", pad, 1'b1);
    check("R10 release oe", pad_oe, 1'b0);
  endtask

  task automatic t_cfg_frozen();
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    cfg_mode = 2'b00; cfg_out_inv = 1'b1;
    sop = 1'b1; tick();
    check("R11 mode change ignored", pad, 1'b0);
    pulse(1'b0);
    check("R11 still D register", pad, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_mode = 2'b00; cfg_out_inv = 1'b0; cfg_gate_pt = 1'b0; cfg_gate_inv = 1'b0;
    gclk = 1'b0; pt_clk = 1'b0; sop = 1'b0; pt_rst = 1'b0; pt_set = 1'b0;
    pt_oe = 1'b0; pl_en = 1'b0; pl_val = 1'b0; observe = 1'b0;
    t_reset_state();
    t_comb();
    t_dreg();
    t_treg();
    t_latch();
    t_async();
    t_preload();
    t_observe();
    t_cfg_frozen();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule